// File: doc/BRIEF.md
# Boot-Time Debug Lock Controller

This block decides, once per reset, whether the debug port may be opened. After reset is released it issues a single read of the protection word from a fixed flash location. It waits for the flash to return the word and compares it with a fixed lock pattern. The debug port is closed only when the word matches the pattern and the image checksum is reported valid. Until that decision is made, debug access stays closed. When the decision is made, a boot-complete level is raised.

The lock is not held in a register that survives reset. It persists because the protection word stays in flash, so every boot locks again. The only way out is a full chip erase. The erase pulse opens the debug port at once, and the erased flash then reads as all ones, so later boots leave debug open. The checksum engine, the flash array and the erase engine lie outside this block and appear only as ports.

Top module: `boot_debug_lock`

## Requirements
- R1: While the reset input is low, boot_done_o, debug_enable_o and flash_rd_o are all low.
- R2: Each boot issues exactly one read strobe. The strobe is one cycle long and carries byte address 0x1FC on flash_addr_o. No read is issued once boot_done_o is high.
- R3: The controller waits any number of cycles for flash_valid_i. It takes flash_data_i only in a cycle where flash_valid_i is high, and ignores the data bus at all other times.
- R4: If the returned word equals 0x87654321 and csum_ok_i is high at decision time, debug_enable_o is low when boot_done_o rises.
- R5: If csum_ok_i is low at decision time, debug_enable_o is high when boot_done_o rises, even when the word matches.
- R6: If the returned word differs from 0x87654321 in any bit, debug_enable_o is high when boot_done_o rises.
- R7: Once boot_done_o is high it stays high until the next reset. Without an erase pulse, debug_enable_o does not change after that point.
- R8: A one-cycle pulse on erase_i after boot completes drives debug_enable_o high from the next cycle. Nothing other than erase_i or reset clears a lock. A boot that follows the erase, with the flash reading all ones, leaves debug enabled.
- R9: An erase pulse seen at any time during the boot check makes that boot finish with debug enabled.
- R10: debug_enable_o stays low from reset release until boot_done_o rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| flash_addr_o | output | ADDR_W | Byte address of the read request |
| flash_rd_o | output | 1 | One-cycle read strobe |
| flash_data_i | input | DATA_W | Read data, valid only together with flash_valid_i |
| flash_valid_i | input | 1 | Read data valid |
| csum_ok_i | input | 1 | Image checksum reported valid |
| erase_i | input | 1 | Full chip erase event pulse |
| debug_enable_o | output | 1 | High when debug access is allowed |
| boot_done_o | output | 1 | Level, high once the lock decision is made |

## Verification
A wrong state in the sequencer shows up directly at the ports. A second read strobe, a missing strobe or a stuck boot_done_o is visible within the boot it affects. A corrupted capture or lock register shows up as a wrong debug_enable_o value in the first cycle after boot_done_o rises. A lock that leaks open, or an erase that does not clear it, changes debug_enable_o one cycle after the stimulus that should or should not have moved it. For that reason the bench compares the level at boot completion against a queued expectation and re-samples it a cycle after every erase pulse.

// File: rtl/boot_lock_pkg.sv
package boot_lock_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_REQ    = 3'd1,
    ST_WAIT   = 3'd2,
    ST_DECIDE = 3'd3,
    ST_DONE   = 3'd4
  } boot_st_e;

endpackage

// File: rtl/boot_rst_sync.sv
module boot_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);

  logic [STAGES-1:0] chain_q;

  // stage 0 takes a constant one; later stages shift it along
  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) chain_q[g] <= 1'b0;
          else         chain_q[g] <= 1'b1;
        end
      end else begin : g_rest
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) chain_q[g] <= 1'b0;
          else         chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  assign rst_no = chain_q[STAGES-1];

endmodule

// File: rtl/boot_seq_fsm.sv
module boot_seq_fsm
  import boot_lock_pkg::*;
#(
  parameter int              ADDR_W    = 24,
  parameter logic [ADDR_W-1:0] PROT_ADDR = 'h1FC
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flash_valid_i,
  output logic              flash_rd_o,
  output logic [ADDR_W-1:0] flash_addr_o,
  output logic              capture_o,
  output logic              decide_o,
  output logic              done_o
);

  boot_st_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   state_d = ST_REQ;
      ST_REQ:    state_d = ST_WAIT;
      ST_WAIT:   if (flash_valid_i) state_d = ST_DECIDE;
      ST_DECIDE: state_d = ST_DONE;
      ST_DONE:   state_d = ST_DONE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign flash_rd_o   = (state_q == ST_REQ);
  assign flash_addr_o = (state_q == ST_REQ) ? PROT_ADDR : '0;
  assign capture_o    = (state_q == ST_WAIT) && flash_valid_i;
  assign decide_o     = (state_q == ST_DECIDE);
  assign done_o       = (state_q == ST_DONE);

  // R2
  rd_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flash_rd_o |=> !flash_rd_o);

  // R2
  no_read_after_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !flash_rd_o);

  // R7
  done_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> done_o);

endmodule

// File: rtl/boot_word_match.sv
module boot_word_match #(
  parameter int                DATA_W = 32,
  parameter logic [DATA_W-1:0] MAGIC  = 32'h8765_4321
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              capture_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              match_o
);

  logic [DATA_W-1:0] word_q, word_d;

  always_comb begin
    word_d = word_q;
    if (capture_i) word_d = data_i;
  end

  // reset value is the complement of the pattern, so it never matches
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) word_q <= ~MAGIC;
    else         word_q <= word_d;
  end

  assign match_o = (word_q == MAGIC);

endmodule

// File: rtl/boot_lock_keeper.sv
module boot_lock_keeper (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic decide_i,
  input  logic match_i,
  input  logic csum_ok_i,
  input  logic erase_i,
  output logic lock_o
);

  logic lock_q, lock_d;
  logic erased_q, erased_d;

  always_comb begin
    erased_d = erased_q | erase_i;
    lock_d   = lock_q;
    if (erase_i)       lock_d = 1'b0;
    else if (decide_i) lock_d = match_i & csum_ok_i & ~erased_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lock_q   <= 1'b0;
      erased_q <= 1'b0;
    end else begin
      lock_q   <= lock_d;
      erased_q <= erased_d;
    end
  end

  assign lock_o = lock_q;

  // R8
  lock_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_o && !erase_i) |=> lock_o);

  // R8
  erase_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    erase_i |=> !lock_o);

  // R4
  lock_needs_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lock_o) |-> $past(match_i && csum_ok_i));

endmodule

// File: rtl/boot_debug_lock.sv
module boot_debug_lock #(
  parameter int                ADDR_W      = 24,
  parameter int                DATA_W      = 32,
  parameter logic [ADDR_W-1:0] PROT_ADDR   = 'h1FC,
  parameter logic [DATA_W-1:0] MAGIC       = 32'h8765_4321,
  parameter int                SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  output logic [ADDR_W-1:0] flash_addr_o,
  output logic              flash_rd_o,
  input  logic [DATA_W-1:0] flash_data_i,
  input  logic              flash_valid_i,
  input  logic              csum_ok_i,
  input  logic              erase_i,
  output logic              debug_enable_o,
  output logic              boot_done_o
);

  logic rst_n;
  logic capture, decide, done, match, lock;

  boot_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_n)
  );

  boot_seq_fsm #(.ADDR_W(ADDR_W), .PROT_ADDR(PROT_ADDR)) u_fsm (
    .clk_i         (clk_i),
    .rst_ni        (rst_n),
    .flash_valid_i (flash_valid_i),
    .flash_rd_o    (flash_rd_o),
    .flash_addr_o  (flash_addr_o),
    .capture_o     (capture),
    .decide_o      (decide),
    .done_o        (done)
  );

  boot_word_match #(.DATA_W(DATA_W), .MAGIC(MAGIC)) u_match (
    .clk_i     (clk_i),
    .rst_ni    (rst_n),
    .capture_i (capture),
    .data_i    (flash_data_i),
    .match_o   (match)
  );

  boot_lock_keeper u_lock (
    .clk_i     (clk_i),
    .rst_ni    (rst_n),
    .decide_i  (decide),
    .match_i   (match),
    .csum_ok_i (csum_ok_i),
    .erase_i   (erase_i),
    .lock_o    (lock)
  );

  assign boot_done_o    = done;
  assign debug_enable_o = done & ~lock;

  // R10
  debug_closed_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    flash_rd_o |-> !debug_enable_o);

endmodule

// File: tb/boot_debug_lock_tb.sv
module boot_debug_lock_tb;

  localparam logic [31:0] MAGIC = 32'h8765_4321;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [23:0] flash_addr;
  logic        flash_rd;
  logic [31:0] flash_data = MAGIC;
  logic        flash_valid = 1'b0;
  logic        csum_ok = 1'b0;
  logic        erase = 1'b0;
  logic        debug_en;
  logic        boot_done;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  logic [31:0] mem_word = MAGIC;
  int          lat = 1;

  bit    exp_q[$];
  string tag_q[$];

  boot_debug_lock u_dut (
    .clk_i          (clk),
    .rst_ni         (rst_ni),
    .flash_addr_o   (flash_addr),
    .flash_rd_o     (flash_rd),
    .flash_data_i   (flash_data),
    .flash_valid_i  (flash_valid),
    .csum_ok_i      (csum_ok),
    .erase_i        (erase),
    .debug_enable_o (debug_en),
    .boot_done_o    (boot_done)
  );

  always #4 clk = ~clk;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // flash model: idle bus carries the pattern with valid low (R3)
  initial begin
    forever begin
      @(negedge clk);
      if (rst_ni && flash_rd) begin
        repeat (lat) @(negedge clk);
        flash_data  = mem_word;
        flash_valid = 1'b1;
        @(negedge clk);
        flash_valid = 1'b0;
        flash_data  = MAGIC;
      end
    end
  end

  // monitor: pops one expectation per boot completion
  initial begin
    bit prev_done = 0;
    int rd_cnt = 0;
    bit bad_addr = 0;
    bit leak = 0;
    forever begin
      @(negedge clk);
      if (!rst_ni) begin
        rd_cnt = 0; bad_addr = 0; leak = 0; prev_done = 0;
      end else begin
        if (flash_rd) begin
          rd_cnt++;
          if (flash_addr != 24'h1FC) bad_addr = 1;
        end
        if (!boot_done && debug_en) leak = 1;
        if (boot_done && !prev_done) begin
          check(!leak, "R10", leak, 0);
          check(rd_cnt == 1 && !bad_addr, "R2", rd_cnt, 1);
          if (exp_q.size() == 0) begin
            check(0, "scoreboard-empty", 0, 1);
          end else begin
            bit e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(debug_en == e, t, debug_en, e);
          end
        end
        if (boot_done && flash_rd) check(0, "R2", 1, 0);
        prev_done = boot_done;
      end
    end
  end

  task automatic boot(input logic [31:0] word, input bit cs, input int l,
                      input bit mid_erase, input bit exp, input string tag);
    mem_word = word;
    csum_ok  = cs;
    lat      = l;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(negedge clk);
    rst_ni = 1'b0;
    repeat (2) @(negedge clk);
    check(!boot_done && !debug_en && !flash_rd, "R1",
          {boot_done, debug_en, flash_rd}, 0);
    rst_ni = 1'b1;
    if (mid_erase) begin
      int n = 0;
      while (!flash_rd && n < 50) begin @(negedge clk); n++; end
      @(negedge clk);
      erase = 1'b1;
      @(negedge clk);
      erase = 1'b0;
    end
    begin
      int n = 0;
      while (!boot_done && n < 200) begin @(negedge clk); n++; end
      check(boot_done, "R7", boot_done, 1);
    end
    repeat (2) @(negedge clk);
  endtask

  initial begin
    bit held;
    repeat (3) @(negedge clk);

    // R4: pattern with valid checksum locks
    boot(MAGIC, 1, 1, 0, 0, "R4");
    held = debug_en;
    repeat (20) @(negedge clk);
    // R7: level and decision hold without erase
    check(boot_done && debug_en == held, "R7", {boot_done, debug_en}, {1'b1, held});
    // R8: nothing else clears the lock, checksum toggling included
    csum_ok = 0;
    repeat (3) @(negedge clk);
    check(!debug_en, "R8", debug_en, 0);
    erase = 1'b1;
    @(negedge clk);
    erase = 1'b0;
    check(debug_en, "R8", debug_en, 1);

    // R8: erased flash reads all ones, next boot stays open
    boot(32'hFFFF_FFFF, 1, 3, 0, 1, "R8");
    // R4: reprogrammed pattern locks again across reset
    boot(MAGIC, 1, 2, 0, 0, "R4");
    // R5: invalid checksum
    boot(MAGIC, 0, 5, 0, 1, "R5");
    // R6: one bit off, pattern sits on idle bus without valid (R3)
    boot(32'h8765_4320, 1, 4, 0, 1, "R6");
    // R3: long wait for valid still locks
    boot(MAGIC, 1, 12, 0, 0, "R3");
    // R9: erase during check
    boot(MAGIC, 1, 8, 1, 1, "R9");

    check(exp_q.size() == 0, "scoreboard-drain", exp_q.size(), 0);
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule